// File: doc/BRIEF.md
# Byte-Lane Synchronous Static Memory Datapath

This block is a synchronous memory array whose words are split into eight byte lanes. On each rising clock edge it captures a word address, write data and the control strobes into input registers. In the cycle after that edge, the captured request either writes the array or reads it. A separate burst address generator supplies the word address already resolved, so this block never computes an address.

A write can be requested in three ways. The first is a per-lane strobe qualified by the write enable. The second is a global write that covers every lane. The third is the write enable with every lane strobe asserted. The write is self-timed from the clock edge, so no external write pulse is needed.

Read data leaves the block in one of two ways, chosen by an elaboration parameter. In pipelined mode, data passes through an output register and appears one cycle after the array access. In flow-through mode, data comes straight from the array. An output enable acts without a clock and gates the data bus. High impedance is modelled by a drive-enable output; the data output reads zero whenever it is not driven.

Top module: `sram_bytewrite`

## Requirements
- R1: After a synchronous reset, `dq_en_o` stays low until a read is registered, and `rdata_o` is all zeros in every cycle where `dq_en_o` is low.
- R2: In flow-through mode (`OUT_MODE = OUT_FLOW`), a read registered at edge t drives the word at the captured address between edge t and edge t+1.
- R3: In pipelined mode (`OUT_MODE = OUT_PIPE`), a read registered at edge t drives that word between edge t+1 and edge t+2.
- R4: Lane k is bits [9k+8:9k]. With `gwr_n_i` high and `wen_n_i` low, lane k is written exactly when `bwe_n_i[k]` is 0. All other lanes keep their contents.
- R5: With `gwr_n_i` low, all eight lanes are written, whatever `wen_n_i` and `bwe_n_i` are.
- R6: With `wen_n_i` low and `bwe_n_i` equal to 8'h00, all eight lanes are written.
- R7: A selected cycle that writes no lane is a read. This covers `gwr_n_i` high together with either `wen_n_i` high or `bwe_n_i` equal to 8'hFF.
- R8: When `cs_n_i` is high at an edge, nothing is written. The bus is then undriven in that request's output slot: the next cycle in flow-through mode, one cycle later in pipelined mode.
- R9: While `oe_n_i` is high, `dq_en_o` is low, with no clock delay.
- R10: The bus is never driven in the output slot of a write.
- R11: A read registered right after a write to the same address returns the newly written lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Resolved word address |
| cs_n_i | input | 1 | Chip select, active low |
| gwr_n_i | input | 1 | Global write of all lanes, active low |
| wen_n_i | input | 1 | Write enable qualifying lane strobes, active low |
| bwe_n_i | input | LANES | Per-lane write strobes, active low |
| oe_n_i | input | 1 | Output enable, unclocked, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driven |
| dq_en_o | output | 1 | Bus drive enable (low means high impedance) |

## Verification
On every cycle, the assertions check the bus-timing rules. These are: the output enable gating the bus (R9), the exact slot in which a read drives (R2, R3), the quiet slots after a deselect (R8) and after a write (R10), and the zero data value when the bus is undriven (R1). What they cannot see is which lanes a write changed or which value a read returns. Only the bench's reference memory shows those, by comparing both output modes against it through lane-by-lane writes, global writes, all-strobe writes, empty-strobe reads and write-then-read sequences.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic {
    OUT_FLOW = 1'b0,
    OUT_PIPE = 1'b1
  } out_mode_e;
endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_n_i,
  input  logic              gwr_n_i,
  input  logic              wen_n_i,
  input  logic [LANES-1:0]  bwe_n_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              sel_q,
  output logic              wr_q,
  output logic [LANES-1:0]  mask_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  logic             every_lane;
  logic [LANES-1:0] lane_req;

  // global write, or write enable with all lane strobes, selects every lane
  always_comb begin
    every_lane = ~gwr_n_i | (~wen_n_i & ~(|bwe_n_i));
    if (every_lane)
      lane_req = '1;
    else if (!wen_n_i)
      lane_req = ~bwe_n_i;
    else
      lane_req = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      sel_q  <= ~cs_n_i;
      mask_q <= cs_n_i ? '0 : lane_req;
    end
    addr_q  <= addr_i;
    wdata_q <= wdata_i;
  end

  assign wr_q = |mask_q;
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i[g])
        mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_pkg::*;
#(
  parameter out_mode_e OUT_MODE = OUT_PIPE,
  parameter int        DATA_W   = 72
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req_i,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic              oe_n_i,
  output logic              dq_en_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              slot_vld;
  logic [DATA_W-1:0] slot_data;

  if (OUT_MODE == OUT_PIPE) begin : g_pipe
    logic              vld_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
      if (rst)
        vld_q <= 1'b0;
      else
        vld_q <= rd_req_i;
      if (rd_req_i)
        data_q <= arr_data_i;
    end

    assign slot_vld  = vld_q;
    assign slot_data = data_q;
  end else begin : g_flow
    logic unused_ok;
    assign unused_ok = clk ^ rst;
    assign slot_vld  = rd_req_i;
    assign slot_data = arr_data_i;
  end

  assign dq_en_o = slot_vld & ~oe_n_i;
  assign rdata_o = dq_en_o ? slot_data : '0;
endmodule

// File: rtl/sram_bytewrite.sv
module sram_bytewrite
  import sram_pkg::*;
#(
  parameter int        ADDR_W   = 6,
  parameter int        LANES    = 8,
  parameter int        LANE_W   = 9,
  parameter out_mode_e OUT_MODE = OUT_PIPE,
  localparam int       DATA_W   = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_n_i,
  input  logic              gwr_n_i,
  input  logic              wen_n_i,
  input  logic [LANES-1:0]  bwe_n_i,
  input  logic              oe_n_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dq_en_o
);
  logic              sel_q;
  logic              wr_q;
  logic [LANES-1:0]  mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] arr_data;

  sram_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (addr_i),
    .cs_n_i  (cs_n_i),
    .gwr_n_i (gwr_n_i),
    .wen_n_i (wen_n_i),
    .bwe_n_i (bwe_n_i),
    .wdata_i (wdata_i),
    .sel_q   (sel_q),
    .wr_q    (wr_q),
    .mask_q  (mask_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk     (clk),
    .we_i    (mask_q),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .rdata_o (arr_data)
  );

  sram_out_stage #(.OUT_MODE(OUT_MODE), .DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .rd_req_i   (sel_q & ~wr_q),
    .arr_data_i (arr_data),
    .oe_n_i     (oe_n_i),
    .dq_en_o    (dq_en_o),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/sram_bytewrite_chk.sv
module sram_bytewrite_chk
  import sram_pkg::*;
#(
  parameter out_mode_e OUT_MODE = OUT_PIPE,
  parameter int        LANES    = 8,
  parameter int        DATA_W   = 72
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n_i,
  input logic              gwr_n_i,
  input logic              wen_n_i,
  input logic [LANES-1:0]  bwe_n_i,
  input logic              oe_n_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              dq_en_o
);
  logic seen = 1'b0;
  logic wr_in;
  logic rd_in;

  always_ff @(posedge clk) seen <= 1'b1;

  assign wr_in = !cs_n_i && (!gwr_n_i || (!wen_n_i && !(&bwe_n_i)));
  assign rd_in = !cs_n_i && !wr_in;

  AST_RESET_QUIET: assert property (@(posedge clk) (seen && $past(rst)) |-> !dq_en_o); // R1
  AST_IDLE_ZERO:   assert property (@(posedge clk) disable iff (rst) !dq_en_o |-> rdata_o == '0); // R1
  AST_OE_BLOCKS:   assert property (@(posedge clk) disable iff (rst) oe_n_i |-> !dq_en_o); // R9

  if (OUT_MODE == OUT_FLOW) begin : g_flow
    AST_FT_READ_SLOT:  assert property (@(posedge clk) disable iff (rst) rd_in |=> (dq_en_o == !oe_n_i)); // R2
    AST_FT_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst) wr_in |=> !dq_en_o); // R10
    AST_FT_DESEL:      assert property (@(posedge clk) disable iff (rst) cs_n_i |=> !dq_en_o); // R8
  end else begin : g_pipe
    AST_PL_READ_SLOT:  assert property (@(posedge clk) disable iff (rst) rd_in |=> ##1 (dq_en_o == !oe_n_i)); // R3
    AST_PL_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst) wr_in |=> ##1 !dq_en_o); // R10
    AST_PL_DESEL:      assert property (@(posedge clk) disable iff (rst) cs_n_i |=> ##1 !dq_en_o); // R8
  end
endmodule

bind sram_bytewrite sram_bytewrite_chk #(
  .OUT_MODE (OUT_MODE),
  .LANES    (LANES),
  .DATA_W   (DATA_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n_i  (cs_n_i),
  .gwr_n_i (gwr_n_i),
  .wen_n_i (wen_n_i),
  .bwe_n_i (bwe_n_i),
  .oe_n_i  (oe_n_i),
  .rdata_o (rdata_o),
  .dq_en_o (dq_en_o)
);

// File: tb/tb_sram_bytewrite.sv
`timescale 1ns/1ps
module tb_sram_bytewrite;
  import sram_pkg::*;

  localparam int AW = 6;
  localparam int NL = 8;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          cs_n = 1'b1, gwr_n = 1'b1, wen_n = 1'b1, oe_n = 1'b0;
  logic [NL-1:0] bwe_n = '1;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rd_pl, rd_ft;
  logic          en_pl, en_ft;

  always #2.5 clk = ~clk;

  sram_bytewrite #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .OUT_MODE(OUT_PIPE)) dut (
    .clk(clk), .rst(rst), .addr_i(addr), .cs_n_i(cs_n), .gwr_n_i(gwr_n),
    .wen_n_i(wen_n), .bwe_n_i(bwe_n), .oe_n_i(oe_n), .wdata_i(wd),
    .rdata_o(rd_pl), .dq_en_o(en_pl));

  sram_bytewrite #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .OUT_MODE(OUT_FLOW)) dut_ft (
    .clk(clk), .rst(rst), .addr_i(addr), .cs_n_i(cs_n), .gwr_n_i(gwr_n),
    .wen_n_i(wen_n), .bwe_n_i(bwe_n), .oe_n_i(oe_n), .wdata_i(wd),
    .rdata_o(rd_ft), .dq_en_o(en_ft));

  int    checks = 0;
  int    bad = 0;
  string cur_req = "R1";
  bit    started = 0;

  // behavioural reference model
  logic [DW-1:0] mm [1<<AW];
  logic          p_sel = 0;
  logic [NL-1:0] p_mask = '0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_wd = '0;
  logic          pv = 0;
  logic [DW-1:0] pd = '0;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      p_sel = 0; p_mask = '0; pv = 0;
    end else begin
      pv = p_sel && (p_mask == '0);
      if (pv) pd = mm[p_addr];
      for (int l = 0; l < NL; l++)
        if (p_mask[l]) mm[p_addr][l*LW +: LW] = p_wd[l*LW +: LW];
      p_sel = !cs_n;
      for (int l = 0; l < NL; l++)
        p_mask[l] = !cs_n && (!gwr_n || (!wen_n && !bwe_n[l]) || (!wen_n && bwe_n == '0));
      p_addr = addr;
      p_wd = wd;
    end
  end

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      logic          ef, ep;
      logic [DW-1:0] df, dp;
      ef = p_sel && (p_mask == '0) && !oe_n && !rst;
      df = ef ? mm[p_addr] : '0;
      ep = pv && !oe_n && !rst;
      dp = ep ? pd : '0;
      chk("flow enable", DW'(en_ft), DW'(ef));
      chk("flow data", rd_ft, df);
      chk("pipe enable", DW'(en_pl), DW'(ep));
      chk("pipe data", rd_pl, dp);
    end
  end

  function automatic logic [DW-1:0] pat(input int a, input int s);
    logic [DW-1:0] v;
    for (int l = 0; l < NL; l++) v[l*LW +: LW] = LW'(a * 37 + l * 53 + s * 11 + 5);
    return v;
  endfunction

  task automatic drive(input logic c, input logic g, input logic w, input logic [NL-1:0] b,
                       input logic o, input int a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    cs_n = c; gwr_n = g; wen_n = w; bwe_n = b; oe_n = o; addr = AW'(a); wd = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1, 1, 1, '1, 0, 0, '0);
  endtask

  task automatic rdc(input int a, input logic o);
    drive(0, 1, 1, '1, o, a, '0);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    cur_req = "R1";
    idle(3);
    @(posedge clk); #1 rst = 0;
    idle(3);

    cur_req = "R5";
    for (int a = 0; a < (1 << AW); a++) drive(0, 0, a[0], NL'(a), 0, a, pat(a, 0));
    idle(2);

    cur_req = "R2 R3";
    for (int a = 0; a < 16; a++) rdc(a, 0);
    idle(2);

    cur_req = "R4";
    for (int i = 0; i < NL; i++) drive(0, 1, 0, ~(NL'(1) << i), 0, 20 + i, pat(i, 9));
    drive(0, 1, 0, 8'h5A, 0, 30, pat(3, 4));
    drive(0, 1, 0, 8'hC3, 0, 31, pat(5, 6));
    for (int i = 0; i < 12; i++) rdc(20 + i, 0);
    idle(2);

    cur_req = "R6";
    drive(0, 1, 0, 8'h00, 0, 40, pat(40, 2));
    rdc(40, 0);
    idle(2);

    cur_req = "R5";
    drive(0, 0, 1, 8'hFF, 0, 41, pat(41, 3));
    drive(0, 0, 0, 8'hAA, 0, 42, pat(42, 3));
    rdc(41, 0); rdc(42, 0);
    idle(2);

    cur_req = "R7";
    drive(0, 1, 0, 8'hFF, 0, 43, pat(1, 1));
    drive(0, 1, 1, 8'h00, 0, 44, pat(1, 1));
    rdc(43, 0); rdc(44, 0);
    idle(2);

    cur_req = "R10";
    for (int i = 0; i < 6; i++) begin
      drive(0, 0, 1, '1, 0, 50 + i, pat(50 + i, 7));
      rdc(i, 0);
    end
    idle(2);

    cur_req = "R11";
    for (int i = 0; i < 4; i++) begin
      drive(0, 1, 0, NL'(8'h0F << i), 0, 10 + i, pat(i, 12));
      rdc(10 + i, 0);
    end
    idle(2);

    cur_req = "R8";
    rdc(1, 0); drive(1, 0, 0, 8'h00, 0, 1, '1); rdc(2, 0); idle(1); rdc(1, 0);
    idle(2);

    cur_req = "R9";
    for (int i = 0; i < 8; i++) rdc(i, i[0]);
    idle(2);

    cur_req = "R4 R5 R6 R7";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[0] & r[1], r[2] | r[3] | r[4], r[5], NL'(r[13:6]), r[14] & r[15],
            int'(r[21:16]), pat(int'(r[29:22]), i));
    end
    idle(3);

    cur_req = "R1";
    @(posedge clk); #1 rst = 1;
    idle(2);
    @(posedge clk); #1 rst = 0;
    idle(3);
    finish_run();
  end
endmodule